// File: doc/BRIEF.md
# Serial I/O Expander Controller

This controller adds up to 128 general-purpose I/O bits to a system. It uses four pins and a chain of external shift registers. The bit stream is divided into 32 ports. Each port carries 1 to 4 bits, and every port carries the same number. A 32-bit enable mask picks which ports take part in the stream. In each frame the controller shifts out the driven value of every enabled bit and samples the returning bit on the input pin. It then raises a load strobe so the external chips latch their outputs, and it publishes the captured inputs to software. Frames repeat for as long as the run bit is set.

The serial clock comes from the reference clock through a programmable divider. Each I/O bit has a polarity bit that inverts both the value driven out and the value read back. The divider, mask and bits-per-port settings can be changed while frames are running. A frame always completes with the settings it started with, and new values are picked up at the frame boundary.

Top module: `serial_gpio_expander`

## Requirements
- R1: After reset the control word reads 0 (not running, one bit per port, divider 0), the port mask reads all ones, the output and polarity words read 0, and the serial clock, load and data-out pins are low.
- R2: A frame visits enabled ports in ascending port order. Within each port it visits bit 0 up to bit (code+1)-1, where code is control bits [2:1]. I/O bit index = port*4 + bit.
- R3: A disabled port gets no serial clock pulses, so a frame has exactly popcount(mask) * (code+1) rising serial clock edges.
- R4: Data out changes only at frame start or when the serial clock falls, never while the clock is high. Data in is sampled when the serial clock rises.
- R5: The value driven for bit i is output[i] XOR polarity[i]. An input word reads as the captured value XOR the polarity word.
- R6: After the last bit, load is high for one serial clock period while the serial clock stays low. Captured inputs become readable at that point. Bits that were not part of the frame keep their previous captured value.
- R7: With divider value N (control bits [15:8]), the serial clock period is 2*(N+1) reference cycles, high for N+1 of them.
- R8: With an all-zero mask, no serial clock pulses occur. Load goes high for one period and low for one period, repeating every 4*(N+1) reference cycles.
- R9: Writes to the mask, bits-per-port code or divider during a frame do not alter that frame. They apply from the next frame.
- R10: Frames repeat back to back while the run bit (control bit 0) is set. Clearing it mid-frame lets the frame, its load pulse and the following gap period finish, after which all pins stay idle.
- R11: Register map: 0 control, 1 port mask, 2-5 output words, 6-9 polarity words, 10-13 input words (read only). Word w holds I/O bits 32w to 32w+31. Control and mask read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| sio_clk | output | 1 | Serial clock to the shift-register chain |
| sio_load | output | 1 | Load strobe to the shift-register chain |
| sio_dout | output | 1 | Serial data to the chain |
| sio_din | input | 1 | Serial data from the chain |

## Verification
The bench targets sparse masks and the all-zero mask. A walker that misses a disabled port, or clocks through it, produces the wrong bit count and a misordered stream. A zero mask would stall the controller or emit stray clocks. A mask rewrite in the middle of a frame checks the boundary rule; a design that applies settings at once truncates the running frame. Polarity is checked in both directions, and input bits left out of a frame are read back to catch a commit that wipes them. The divider is checked by measuring period and duty cycle. Run is cleared mid-frame to catch a controller that stops abruptly or never stops.

// File: rtl/sgx_pkg.sv
`timescale 1ns/100ps
// Shared types and fixed register addresses of the serial I/O expander.
// Assumes the data word is 32 bits wide.
package sgx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2,
        ST_GAP   = 2'd3
    } sgx_state_e;

    localparam int SGX_DATA_W   = 32;
    localparam int SGX_ADR_CTRL = 0;
    localparam int SGX_ADR_MASK = 1;
    localparam int SGX_ADR_OUT  = 2;
endpackage

// File: rtl/sgx_regs.sv
`timescale 1ns/100ps
// Register file: control, port mask, output and polarity words, committed
// input capture. Reads are combinational.
// Assumes NUM_PORTS <= 32, DIV_W <= 24 and that ADDR_W can reach 2+3*words.
module sgx_regs #(
    parameter int NUM_PORTS = 32,
    parameter int MAX_BPP   = 4,
    parameter int DIV_W     = 8,
    parameter int ADDR_W    = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [ADDR_W-1:0]                    wr_addr,
    input  logic [31:0]                          wr_data,
    input  logic [ADDR_W-1:0]                    rd_addr,
    output logic [31:0]                          rd_data,
    input  logic                                 commit,
    input  logic [NUM_PORTS*MAX_BPP-1:0]         cap_bits,
    output logic                                 run,
    output logic [$clog2(MAX_BPP)-1:0]           bpp_code,
    output logic [DIV_W-1:0]                     div_val,
    output logic [NUM_PORTS-1:0]                 port_mask,
    output logic [NUM_PORTS*MAX_BPP-1:0]         out_bits,
    output logic [NUM_PORTS*MAX_BPP-1:0]         pol_bits
);
    import sgx_pkg::*;

    localparam int IO_W   = NUM_PORTS * MAX_BPP;
    localparam int NW     = IO_W / SGX_DATA_W;
    localparam int BPP_W  = $clog2(MAX_BPP);
    localparam int ADR_POL = SGX_ADR_OUT + NW;
    localparam int ADR_IN  = SGX_ADR_OUT + 2 * NW;

    logic                  run_q;
    logic [BPP_W-1:0]      bpp_q;
    logic [DIV_W-1:0]      div_q;
    logic [NUM_PORTS-1:0]  mask_q;
    logic [NW-1:0][31:0]   out_q;
    logic [NW-1:0][31:0]   pol_q;
    logic [IO_W-1:0]       in_raw_q;

    // Control word and port mask writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            bpp_q  <= '0;
            div_q  <= '0;
            mask_q <= '1;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(SGX_ADR_CTRL)) begin
                run_q <= wr_data[0];
                bpp_q <= wr_data[BPP_W:1];
                div_q <= wr_data[8 +: DIV_W];
            end
            if (wr_addr == ADDR_W'(SGX_ADR_MASK))
                mask_q <= wr_data[NUM_PORTS-1:0];
        end
    end

    for (genvar w = 0; w < NW; w++) begin : g_word
        // Output and polarity word w.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_q[w] <= '0;
                pol_q[w] <= '0;
            end else if (wr_en) begin
                if (wr_addr == ADDR_W'(SGX_ADR_OUT + w)) out_q[w] <= wr_data;
                if (wr_addr == ADDR_W'(ADR_POL + w))     pol_q[w] <= wr_data;
            end
        end
    end

    // Captured inputs become visible only when the sequencer commits.
    always_ff @(posedge clk) begin
        if (!rst_n)      in_raw_q <= '0;
        else if (commit) in_raw_q <= cap_bits;
    end

    // Read multiplexer; input words are returned with polarity applied.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(SGX_ADR_CTRL)) begin
            rd_data[0]          = run_q;
            rd_data[BPP_W:1]    = bpp_q;
            rd_data[8 +: DIV_W] = div_q;
        end
        if (rd_addr == ADDR_W'(SGX_ADR_MASK))
            rd_data = SGX_DATA_W'(mask_q);
        for (int w = 0; w < NW; w++) begin
            if (rd_addr == ADDR_W'(SGX_ADR_OUT + w)) rd_data = out_q[w];
            if (rd_addr == ADDR_W'(ADR_POL + w))     rd_data = pol_q[w];
            if (rd_addr == ADDR_W'(ADR_IN + w))
                rd_data = in_raw_q[w*32 +: 32] ^ pol_q[w];
        end
    end

    assign run       = run_q;
    assign bpp_code  = bpp_q;
    assign div_val   = div_q;
    assign port_mask = mask_q;
    assign out_bits  = out_q;
    assign pol_bits  = pol_q;

    AST_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(in_raw_q)); // R6
endmodule

// File: rtl/sgx_tick.sv
`timescale 1ns/100ps
// Half-period tick generator: pulses once every div+1 reference cycles
// while active, and holds at zero otherwise.
// Assumes div only changes on a cycle where the count restarts.
module sgx_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = active && (cnt_q == div);

    // Count reference cycles within one half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) cnt_q <= '0;
        else if (tick)         cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q <= div)); // R7
endmodule

// File: rtl/sgx_seq.sv
`timescale 1ns/100ps
// Frame sequencer: walks the enabled ports and their bits, drives the
// serial clock, data out and load pins, and samples data in.
// Settings are latched at each frame boundary.
// Assumes MAX_BPP and NUM_PORTS are powers of two, at least 2.
module sgx_seq #(
    parameter int NUM_PORTS = 32,
    parameter int MAX_BPP   = 4,
    parameter int DIV_W     = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           run,
    input  logic [NUM_PORTS-1:0]           mask_cfg,
    input  logic [$clog2(MAX_BPP)-1:0]     bpp_cfg,
    input  logic [DIV_W-1:0]               div_cfg,
    input  logic [NUM_PORTS*MAX_BPP-1:0]   out_bits,
    input  logic [NUM_PORTS*MAX_BPP-1:0]   pol_bits,
    input  logic                           sdi,
    input  logic                           tick,
    output logic                           active,
    output logic [DIV_W-1:0]               div_lat,
    output logic                           sclk,
    output logic                           sload,
    output logic                           sdo,
    output logic                           commit,
    output logic [NUM_PORTS*MAX_BPP-1:0]   cap_bits
);
    import sgx_pkg::*;

    localparam int IO_W   = NUM_PORTS * MAX_BPP;
    localparam int IDX_W  = $clog2(IO_W);
    localparam int PORT_W = $clog2(NUM_PORTS);
    localparam int BPP_W  = $clog2(MAX_BPP);

    sgx_state_e           state_q;
    logic [NUM_PORTS-1:0] mask_l;
    logic [BPP_W-1:0]     bpp_l;
    logic [DIV_W-1:0]     div_q;
    logic [PORT_W-1:0]    port_q;
    logic [BPP_W-1:0]     bit_q;
    logic                 half_q, sclk_q, sload_q, sdo_q;
    logic [IO_W-1:0]      cap_q;

    // Lowest enabled port at or above 'from'; MSB flags that one exists.
    function automatic logic [PORT_W:0] find_port(input logic [NUM_PORTS-1:0] m,
                                                  input logic [PORT_W:0] from);
        logic [PORT_W:0] r;
        r = '0;
        for (int i = NUM_PORTS - 1; i >= 0; i--)
            if (m[i] && ((PORT_W+1)'(i) >= from)) r = {1'b1, PORT_W'(i)};
        return r;
    endfunction

    logic [PORT_W:0] first_sel, next_sel;
    logic [IDX_W-1:0] cur_idx, first_idx, next_idx;
    logic last_bit, boundary, stop;

    assign first_sel = find_port(mask_cfg, '0);
    assign next_sel  = find_port(mask_l, {1'b0, port_q} + (PORT_W+1)'(1));
    assign cur_idx   = IDX_W'(port_q) * IDX_W'(MAX_BPP) + IDX_W'(bit_q);
    assign first_idx = IDX_W'(first_sel[PORT_W-1:0]) * IDX_W'(MAX_BPP);
    assign next_idx  = IDX_W'(next_sel[PORT_W-1:0]) * IDX_W'(MAX_BPP);
    assign last_bit  = (bit_q == bpp_l);
    assign boundary  = run && ((state_q == ST_IDLE) ||
                               (state_q == ST_GAP && tick && half_q));
    assign stop      = !run && state_q == ST_GAP && tick && half_q;
    assign commit    = (state_q == ST_SHIFT) && tick && sclk_q && last_bit &&
                       !next_sel[PORT_W];

    // Frame state machine and pin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_l  <= '0;
            bpp_l   <= '0;
            div_q   <= '0;
            port_q  <= '0;
            bit_q   <= '0;
            half_q  <= 1'b0;
            sclk_q  <= 1'b0;
            sload_q <= 1'b0;
            sdo_q   <= 1'b0;
        end else if (boundary) begin
            mask_l <= mask_cfg;
            bpp_l  <= bpp_cfg;
            div_q  <= div_cfg;
            half_q <= 1'b0;
            sclk_q <= 1'b0;
            bit_q  <= '0;
            if (first_sel[PORT_W]) begin
                state_q <= ST_SHIFT;
                port_q  <= first_sel[PORT_W-1:0];
                sload_q <= 1'b0;
                sdo_q   <= out_bits[first_idx] ^ pol_bits[first_idx];
            end else begin
                state_q <= ST_LOAD;
                sload_q <= 1'b1;
                sdo_q   <= 1'b0;
            end
        end else if (stop) begin
            state_q <= ST_IDLE;
            half_q  <= 1'b0;
        end else if (tick) begin
            case (state_q)
                ST_SHIFT: begin
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                    end else begin
                        sclk_q <= 1'b0;
                        if (!last_bit) begin
                            bit_q <= bit_q + 1'b1;
                            sdo_q <= out_bits[cur_idx + 1'b1] ^ pol_bits[cur_idx + 1'b1];
                        end else if (next_sel[PORT_W]) begin
                            port_q <= next_sel[PORT_W-1:0];
                            bit_q  <= '0;
                            sdo_q  <= out_bits[next_idx] ^ pol_bits[next_idx];
                        end else begin
                            state_q <= ST_LOAD;
                            sload_q <= 1'b1;
                            sdo_q   <= 1'b0;
                        end
                    end
                end
                ST_LOAD: begin
                    half_q <= !half_q;
                    if (half_q) begin
                        sload_q <= 1'b0;
                        state_q <= ST_GAP;
                    end
                end
                ST_GAP:  half_q <= 1'b1;
                default: half_q <= 1'b0;
            endcase
        end
    end

    // Sample data in on the rising serial clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else if (state_q == ST_SHIFT && tick && !sclk_q) cap_q[cur_idx] <= sdi;
    end

    assign active   = (state_q != ST_IDLE);
    assign div_lat  = div_q;
    assign sclk     = sclk_q;
    assign sload    = sload_q;
    assign sdo      = sdo_q;
    assign cap_bits = cap_q;

    AST_LOAD_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        sload_q |-> !sclk_q); // R6
    AST_SDO_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_q) |-> $stable(sdo_q)); // R4
    AST_CLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sclk_q)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!sclk_q && !sload_q)); // R10
    AST_SHIFT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> mask_l[port_q]); // R3
endmodule

// File: rtl/serial_gpio_expander.sv
`timescale 1ns/100ps
// Serial I/O expander top: register file, tick generator and frame
// sequencer driving a four-pin shift-register chain.
// Assumes the register interface and pins share the reference clock.
module serial_gpio_expander #(
    parameter int NUM_PORTS = 32,
    parameter int MAX_BPP   = 4,
    parameter int DIV_W     = 8,
    parameter int ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              sio_clk,
    output logic              sio_load,
    output logic              sio_dout,
    input  logic              sio_din
);
    localparam int IO_W  = NUM_PORTS * MAX_BPP;
    localparam int BPP_W = $clog2(MAX_BPP);

    logic                 run, commit, active, tick;
    logic [BPP_W-1:0]     bpp_code;
    logic [DIV_W-1:0]     div_val, div_lat;
    logic [NUM_PORTS-1:0] port_mask;
    logic [IO_W-1:0]      out_bits, pol_bits, cap_bits;

    sgx_regs #(.NUM_PORTS(NUM_PORTS), .MAX_BPP(MAX_BPP), .DIV_W(DIV_W),
               .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .commit(commit), .cap_bits(cap_bits), .run(run), .bpp_code(bpp_code),
        .div_val(div_val), .port_mask(port_mask), .out_bits(out_bits),
        .pol_bits(pol_bits)
    );

    sgx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .active(active), .div(div_lat), .tick(tick)
    );

    sgx_seq #(.NUM_PORTS(NUM_PORTS), .MAX_BPP(MAX_BPP), .DIV_W(DIV_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .mask_cfg(port_mask),
        .bpp_cfg(bpp_code), .div_cfg(div_val), .out_bits(out_bits),
        .pol_bits(pol_bits), .sdi(sio_din), .tick(tick), .active(active),
        .div_lat(div_lat), .sclk(sio_clk), .sload(sio_load), .sdo(sio_dout),
        .commit(commit), .cap_bits(cap_bits)
    );
endmodule

// File: tb/serial_gpio_expander_tb.sv
`timescale 1ns/100ps
// Directed bench: one task per scenario, each checking its own results.
module serial_gpio_expander_tb;
    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, sio_din = 1'b0;
    logic [3:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic        sio_clk, sio_load, sio_dout;

    serial_gpio_expander u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sio_clk(sio_clk), .sio_load(sio_load), .sio_dout(sio_dout),
        .sio_din(sio_din)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;
    logic [127:0] out_m, pol_m, in_m, pat, got;
    int nbits, rise0, rise1, fall0, load_len, cyc;
    bit clk_in_load, sdo_move;
    int chg_at = -1;
    logic [3:0]  chg_addr;
    logic [31:0] chg_val;

    function automatic logic [31:0] ctrl(input bit run, input int code, input int dv);
        return {16'h0, 8'(dv), 5'h0, 2'(code), run};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); rd_addr = a; #1 d = rd_data;
    endtask

    task automatic load_model_regs();
        for (int w = 0; w < 4; w++) begin
            write_reg(4'(2 + w), out_m[w*32 +: 32]);
            write_reg(4'(6 + w), pol_m[w*32 +: 32]);
        end
    endtask

    // Follow one frame from now until its load pulse ends.
    task automatic run_frame(input bit do_stop, input logic [31:0] stop_word);
        logic pc, pl, pd;
        bit chg_done;
        nbits = 0; rise0 = -1; rise1 = -1; fall0 = -1; load_len = 0;
        clk_in_load = 0; sdo_move = 0; cyc = 0; chg_done = 0;
        pc = sio_clk; pl = sio_load; pd = sio_dout; sio_din = pat[0];
        forever begin
            @(negedge clk); cyc++; wr_en = 1'b0;
            if (chg_at >= 0 && !chg_done && nbits == chg_at) begin
                wr_en = 1'b1; wr_addr = chg_addr; wr_data = chg_val; chg_done = 1;
            end
            if (sio_clk && pc && sio_dout !== pd) sdo_move = 1;
            if (sio_clk && !pc) begin
                if (nbits < 128) got[nbits] = sio_dout;
                if (rise0 < 0) rise0 = cyc; else if (rise1 < 0) rise1 = cyc;
                nbits++;
            end
            if (!sio_clk && pc) begin
                if (fall0 < 0) fall0 = cyc;
                if (nbits < 128) sio_din = pat[nbits];
            end
            pc = sio_clk; pd = sio_dout;
            if ((sio_load && !pl) || cyc > 20000) break;
            pl = sio_load;
        end
        if (do_stop) begin
            wr_en = 1'b1; wr_addr = 4'd0; wr_data = stop_word;
        end
        while (sio_load && load_len < 1000) begin
            if (sio_clk) clk_in_load = 1;
            load_len++;
            @(negedge clk); wr_en = 1'b0;
        end
        wr_en = 1'b0;
    endtask

    // Compare the captured stream against the model and update input model.
    task automatic check_frame(input string req, input logic [31:0] mask, input int bpp);
        int k = 0, err = 0;
        for (int p = 0; p < 32; p++) begin
            if (mask[p]) begin
                for (int b = 0; b < bpp; b++) begin
                    if (k < 128 && got[k] !== (out_m[p*4+b] ^ pol_m[p*4+b])) err++;
                    if (k < 128) in_m[p*4+b] = pat[k];
                    k++;
                end
            end
        end
        chk({req, " R3 bit count"}, nbits, k);
        chk({req, " R2 bit order/value"}, err, 0);
    endtask

    task automatic check_inputs(input string req);
        logic [31:0] d;
        for (int w = 0; w < 4; w++) begin
            read_reg(4'(10 + w), d);
            chk(req, d, in_m[w*32 +: 32] ^ pol_m[w*32 +: 32]);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        read_reg(4'd0, d); chk("R1 ctrl reset", d, 32'h0);
        read_reg(4'd1, d); chk("R1 mask reset", d, 32'hFFFF_FFFF);
        read_reg(4'd2, d); chk("R1 out reset", d, 32'h0);
        read_reg(4'd6, d); chk("R1 pol reset", d, 32'h0);
        chk("R1 pins idle", {29'h0, sio_clk, sio_load, sio_dout}, 32'h0);
        write_reg(4'd0, ctrl(0, 2, 5));
        read_reg(4'd0, d); chk("R11 ctrl readback", d, ctrl(0, 2, 5));
        write_reg(4'd1, 32'h1234_8421);
        read_reg(4'd1, d); chk("R11 mask readback", d, 32'h1234_8421);
        in_m = '0;
    endtask

    task automatic t_full();
        out_m = {32'h1234_5678, 32'hF00D_CAFE, 32'h0F0F_A5A5, 32'h8001_7E3C};
        pol_m = '0;
        pat   = {32'hDEAD_BEEF, 32'h0123_4567, 32'hC3C3_1111, 32'h5A5A_9999};
        load_model_regs();
        write_reg(4'd1, 32'hFFFF_FFFF);
        chg_at = -1; sio_din = pat[0];
        write_reg(4'd0, ctrl(1, 3, 1));
        run_frame(1, ctrl(0, 3, 1));
        check_frame("full", 32'hFFFF_FFFF, 4);
        chk("R6 load length", load_len, 4);
        chk("R6 no clock during load", clk_in_load, 0);
        chk("R4 dout steady while clock high", sdo_move, 0);
        check_inputs("R6 inputs committed");
        repeat (100) @(negedge clk);
    endtask

    task automatic t_sparse_pol();
        out_m = {32'h0000_FFFF, 32'h3C3C_3C3C, 32'h9876_5432, 32'h0F1E_2D3C};
        pol_m = {32'hFFFF_0000, 32'h00FF_00FF, 32'h1357_9BDF, 32'hF0F0_0F0F};
        pat   = {32'h7777_0000, 32'hABCD_EF01, 32'h2468_ACE0, 32'hFEDC_BA98};
        load_model_regs();
        write_reg(4'd1, 32'h8000_0125);
        sio_din = pat[0];
        write_reg(4'd0, ctrl(1, 1, 0));
        run_frame(1, ctrl(0, 1, 0));
        check_frame("sparse R5", 32'h8000_0125, 2);
        check_inputs("R5 input polarity, R6 untouched bits kept");
        repeat (100) @(negedge clk);
    endtask

    task automatic t_div();
        pat = '0;
        write_reg(4'd1, 32'h0000_0003);
        sio_din = pat[0];
        write_reg(4'd0, ctrl(1, 1, 3));
        run_frame(1, ctrl(0, 1, 3));
        check_frame("div", 32'h0000_0003, 2);
        chk("R7 clock period", rise1 - rise0, 8);
        chk("R7 clock high time", fall0 - rise0, 4);
        chk("R6 load one period", load_len, 8);
        check_inputs("R6 div inputs");
        repeat (100) @(negedge clk);
    endtask

    task automatic t_zero();
        int rises = 0, lr0 = -1, lr1 = -1, hi = 0;
        logic pc, pl;
        write_reg(4'd1, 32'h0);
        write_reg(4'd0, ctrl(1, 0, 1));
        pc = sio_clk; pl = sio_load;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (sio_clk && !pc) rises++;
            if (sio_load && !pl) begin
                if (lr0 < 0) lr0 = c; else if (lr1 < 0) lr1 = c;
            end
            if (sio_load && lr1 < 0 && lr0 >= 0) hi++;
            pc = sio_clk; pl = sio_load;
        end
        chk("R8 no clock pulses", rises, 0);
        chk("R8 load interval", lr1 - lr0, 8);
        chk("R8 load high time", hi, 4);
        write_reg(4'd0, ctrl(0, 0, 1));
        repeat (100) @(negedge clk);
        check_inputs("R8 inputs unchanged");
    endtask

    task automatic t_cfg();
        pat = {32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h0F0F_F0F0};
        write_reg(4'd1, 32'hFFFF_FFFF);
        sio_din = pat[0];
        chg_at = 5; chg_addr = 4'd1; chg_val = 32'h0000_000F;
        write_reg(4'd0, ctrl(1, 0, 0));
        run_frame(0, 32'h0);
        chg_at = -1;
        check_frame("R9 current frame", 32'hFFFF_FFFF, 1);
        pat = ~pat;
        run_frame(1, ctrl(0, 0, 0));
        chk("R10 frames repeat", nbits > 0, 1);
        check_frame("R9 next frame", 32'h0000_000F, 1);
        repeat (100) @(negedge clk);
        check_inputs("R9 inputs");
    endtask

    task automatic t_stop();
        int rises = 0, loads = 0;
        logic pc, pl;
        logic [31:0] d;
        pat = {4{32'h9696_6969}};
        write_reg(4'd1, 32'h0000_00FF);
        sio_din = pat[0];
        chg_at = 2; chg_addr = 4'd0; chg_val = ctrl(0, 0, 0);
        write_reg(4'd0, ctrl(1, 0, 0));
        run_frame(0, 32'h0);
        chg_at = -1;
        check_frame("R10 frame completes", 32'h0000_00FF, 1);
        chk("R10 load after stop", load_len, 2);
        pc = sio_clk; pl = sio_load;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (sio_clk && !pc) rises++;
            if (sio_load && !pl) loads++;
            pc = sio_clk; pl = sio_load;
        end
        chk("R10 idle clock", rises, 0);
        chk("R10 idle load", loads, 0);
        read_reg(4'd0, d); chk("R10 run cleared", d, ctrl(0, 0, 0));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_sparse_pol();
        t_div();
        t_zero();
        t_cfg();
        t_stop();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule